// File: doc/BRIEF.md
# Bus Hold Arbitration and Float Controller

This block sits in the bus interface of a CPU-style bus master. It decides when an external agent that raises a hold request may take the bus. It sequences the master's own bus states: idle, first cycle, active cycle and hold. While the bus is surrendered, it produces the hold acknowledge and a vector of output enables that floats the address, data, strobe and control pin groups.

The grant is deferred in two cases. It waits while a locked sequence is in progress. It also waits for the second half of an operand that a half-width bus splits into two narrow cycles. During hold, every input except the hold request and reset is ignored. The only exception is one rising edge on the non-maskable interrupt line, which is remembered and reported as a one-cycle event when hold ends. Reset overrides hold and discards any remembered edge. If the hold request is still high when reset is released, the bus is handed over before the first bus cycle starts.

Top module: `bus_hold_ctrl`

## Requirements
- R1: The state `bus_state` is encoded as 0 = idle, 1 = first cycle, 2 = active cycle and 3 = hold. From idle, a sampled-high `hold_req` moves the state to hold on the next edge, taking priority over `bus_req`. From the active cycle, hold is entered on the edge where `ready_in` is high and `hold_req` is high.
- R2: When `lock_in` is high at the edge that ends an active cycle, the state does not go to hold. It goes to first cycle if `bus_req` is high, and to idle otherwise.
- R3: An active cycle that ends with `narrow_in` high and is the first half of a transfer always continues with a second cycle (state 1, then 2). Hold can only be granted at the end of that second half.
- R4: `hold_ack` rises one clock after the state becomes hold and falls one clock after the state leaves hold. Every bit of `pin_oe` is 0 exactly while `hold_ack` is 1, and 1 otherwise.
- R5: A rising edge on `nmi_in` sampled while in hold is captured. On the clock edge where hold is left, `nmi_evt` is high for exactly one cycle, however many edges occurred during that hold. Edges seen outside hold produce no event.
- R6: While in hold with `hold_req` high, `lock_in`, `bus_req`, `ready_in` and `narrow_in` have no effect, and the state stays 3.
- R7: When `hold_req` is sampled low in hold, the next state is first cycle if `bus_req` is high, and idle otherwise.
- R8: A high `rst` forces idle, drops `hold_ack`, re-enables all outputs and clears a captured NMI edge, even while in hold.
- R9: If `hold_req` is high on the first edge after `rst` is released, the state goes directly to hold, even when `bus_req` is also high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset, highest priority |
| hold_req | input | 1 | External request to take over the bus |
| nmi_in | input | 1 | Non-maskable interrupt line, edge-sensitive during hold |
| lock_in | input | 1 | Locked sequence in progress; blocks the grant at cycle end |
| bus_req | input | 1 | Internal bus request pending |
| ready_in | input | 1 | Current bus cycle acknowledged |
| narrow_in | input | 1 | Current transfer uses the half-width bus |
| hold_ack | output | 1 | Hold acknowledge |
| pin_oe | output | OE_W | Output enable per pin group, 0 = floated |
| bus_state | output | 2 | Current bus state (encoding in R1) |
| nmi_evt | output | 1 | One-cycle pulse: an NMI edge was captured during the hold just left |

## Verification
The situation hardest to reach from the ports is a hold request that meets a cycle boundary where a grant would be illegal. Examples are a locked cycle end, or the first half of a narrow transfer, with the request already high. The stimulus keeps `hold_req` high across those boundaries and checks that the grant appears only at the next legal boundary. It also pulses `nmi_in` twice during one hold while toggling the ignored inputs, then asserts reset in the middle of a hold that has captured an edge. This shows that the edge is discarded and that hold is taken again straight after reset.

// File: rtl/bhc_pkg.sv
package bhc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_T1   = 2'd1,
        ST_ACT  = 2'd2,
        ST_HOLD = 2'd3
    } bus_st_e;

    // grant is legal at a cycle boundary only outside a locked sequence
    function automatic logic grant_ok(input logic hold, input logic lock);
        return hold && !lock;
    endfunction

    // state taken when the bus is not surrendered and no cycle continues
    function automatic bus_st_e next_free(input logic req);
        return req ? ST_T1 : ST_IDLE;
    endfunction

endpackage

// File: rtl/bhc_fsm.sv
module bhc_fsm
    import bhc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    hold_req,
    input  logic    lock_in,
    input  logic    bus_req,
    input  logic    ready_in,
    input  logic    narrow_in,
    output bus_st_e st_q,
    output logic    in_hold,
    output logic    hold_exit
);

    bus_st_e st_d;
    logic    half_q, half_d;

    always_comb begin
        st_d   = st_q;
        half_d = half_q;
        unique case (st_q)
            ST_IDLE: begin
                if (hold_req) st_d = ST_HOLD;
                else          st_d = next_free(bus_req);
            end
            ST_T1: st_d = ST_ACT;
            ST_ACT: begin
                if (ready_in) begin
                    if (narrow_in && !half_q) begin
                        half_d = 1'b1;
                        st_d   = ST_T1;
                    end else begin
                        half_d = 1'b0;
                        if (grant_ok(hold_req, lock_in)) st_d = ST_HOLD;
                        else                             st_d = next_free(bus_req);
                    end
                end
            end
            ST_HOLD: begin
                if (!hold_req) st_d = next_free(bus_req);
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            half_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            half_q <= half_d;
        end
    end

    assign in_hold   = (st_q == ST_HOLD);
    assign hold_exit = in_hold && !hold_req;

    a_r2_lock_defers: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ACT && ready_in && lock_in) |=> (st_q != ST_HOLD));

    a_r3_split_second: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ACT && ready_in && narrow_in && !half_q) |=> (st_q == ST_T1));

    a_r6_hold_sticky: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HOLD && hold_req) |=> (st_q == ST_HOLD));

    a_r7_exit_idle: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HOLD && !hold_req && !bus_req) |=> (st_q == ST_IDLE));

    a_r7_exit_t1: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HOLD && !hold_req && bus_req) |=> (st_q == ST_T1));

endmodule

// File: rtl/bhc_nmi_latch.sv
module bhc_nmi_latch (
    input  logic clk,
    input  logic rst,
    input  logic nmi_in,
    input  logic in_hold,
    input  logic hold_exit,
    output logic nmi_evt
);

    logic prev_q;
    logic seen_q;
    logic edge_now;
    logic evt_q;

    assign edge_now = nmi_in && !prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            seen_q <= 1'b0;
            evt_q  <= 1'b0;
        end else begin
            prev_q <= nmi_in;
            evt_q  <= hold_exit && (seen_q || edge_now);
            if (hold_exit || !in_hold)  seen_q <= 1'b0;
            else if (edge_now)          seen_q <= 1'b1;
        end
    end

    assign nmi_evt = evt_q;

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        nmi_evt |=> !nmi_evt);

    a_r5_evt_on_exit: assert property (@(posedge clk) disable iff (rst)
        (!hold_exit) |=> !nmi_evt);

    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> !nmi_evt);

endmodule

// File: rtl/bhc_float.sv
module bhc_float
    import bhc_pkg::*;
#(
    parameter int OE_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_hold,
    output logic            hold_ack,
    output logic [OE_W-1:0] pin_oe
);

    logic ack_q;

    always_ff @(posedge clk) begin
        if (rst) ack_q <= 1'b0;
        else     ack_q <= in_hold;
    end

    assign hold_ack = ack_q;

    for (genvar g = 0; g < OE_W; g++) begin : g_grp
        assign pin_oe[g] = !ack_q;
    end

    a_r4_ack_follows: assert property (@(posedge clk) disable iff (rst)
        in_hold |=> hold_ack);

    a_r4_ack_drops: assert property (@(posedge clk) disable iff (rst)
        !in_hold |=> (!hold_ack && (&pin_oe)));

    a_r8_reset_ack: assert property (@(posedge clk)
        rst |=> (!hold_ack && (&pin_oe)));

endmodule

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl
    import bhc_pkg::*;
#(
    parameter int OE_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hold_req,
    input  logic            nmi_in,
    input  logic            lock_in,
    input  logic            bus_req,
    input  logic            ready_in,
    input  logic            narrow_in,
    output logic            hold_ack,
    output logic [OE_W-1:0] pin_oe,
    output logic [1:0]      bus_state,
    output logic            nmi_evt
);

    bus_st_e st;
    logic    in_hold;
    logic    hold_exit;

    bhc_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .hold_req  (hold_req),
        .lock_in   (lock_in),
        .bus_req   (bus_req),
        .ready_in  (ready_in),
        .narrow_in (narrow_in),
        .st_q      (st),
        .in_hold   (in_hold),
        .hold_exit (hold_exit)
    );

    bhc_nmi_latch u_nmi (
        .clk       (clk),
        .rst       (rst),
        .nmi_in    (nmi_in),
        .in_hold   (in_hold),
        .hold_exit (hold_exit),
        .nmi_evt   (nmi_evt)
    );

    bhc_float #(.OE_W(OE_W)) u_float (
        .clk      (clk),
        .rst      (rst),
        .in_hold  (in_hold),
        .hold_ack (hold_ack),
        .pin_oe   (pin_oe)
    );

    assign bus_state = st;

    a_r9_hold_after_reset: assert property (@(posedge clk)
        (rst ##1 (!rst && hold_req)) |=> (bus_state == 2'd3));

endmodule

// File: tb/bus_hold_ctrl_test.sv
module bus_hold_ctrl_test;

    localparam int OE_W = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            hold_req = 1'b0, nmi_in = 1'b0, lock_in = 1'b0;
    logic            bus_req = 1'b0, ready_in = 1'b0, narrow_in = 1'b0;
    logic            hold_ack;
    logic [OE_W-1:0] pin_oe;
    logic [1:0]      bus_state;
    logic            nmi_evt;

    typedef struct {
        logic [1:0] st;
        logic       ack;
        logic       evt;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    bus_hold_ctrl #(.OE_W(OE_W)) uut (
        .clk(clk), .rst(rst), .hold_req(hold_req), .nmi_in(nmi_in),
        .lock_in(lock_in), .bus_req(bus_req), .ready_in(ready_in),
        .narrow_in(narrow_in), .hold_ack(hold_ack), .pin_oe(pin_oe),
        .bus_state(bus_state), .nmi_evt(nmi_evt)
    );

    // driver: applies inputs at the falling edge, queues outputs expected after the next rising edge
    task automatic step(input logic r, input logic h, input logic n, input logic l,
                        input logic q, input logic y, input logic w,
                        input logic [1:0] st, input logic ack, input logic evt,
                        input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; hold_req = h; nmi_in = n; lock_in = l;
        bus_req = q; ready_in = y; narrow_in = w;
        e.st = st; e.ack = ack; e.evt = evt; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: compares a quarter period after each rising edge
    always @(posedge clk) begin
        #5;
        if (exp_q.size() > 0) begin
            exp_t e;
            logic [OE_W-1:0] oe_exp;
            e = exp_q.pop_front();
            oe_exp = e.ack ? '0 : '1;
            n_chk++;
            if (bus_state !== e.st || hold_ack !== e.ack || nmi_evt !== e.evt || pin_oe !== oe_exp) begin
                n_err++;
                $display("FAIL %s: got st=%0d ack=%b evt=%b oe=%h, expected st=%0d ack=%b evt=%b oe=%h",
                         e.tag, bus_state, hold_ack, nmi_evt, pin_oe, e.st, e.ack, e.evt, oe_exp);
            end
        end
    end

    initial begin
        // rst hold nmi lock req rdy nar | st ack evt
        step(1,0,0,0,0,0,0, 0,0,0, "R8 reset state");
        step(1,0,0,0,0,0,0, 0,0,0, "R8 reset state");
        // R1 hold from idle, priority over bus_req; R4 ack timing; R7 exit to idle
        step(0,0,0,0,0,0,0, 0,0,0, "R1 idle");
        step(0,1,0,0,1,0,0, 3,0,0, "R1 hold from idle over request");
        step(0,1,0,0,0,0,0, 3,1,0, "R4 ack one clock later");
        step(0,0,0,0,0,0,0, 0,1,0, "R7 exit to idle");
        step(0,0,0,0,0,0,0, 0,0,0, "R4 ack falls");
        // R2 lock defers the grant
        step(0,0,0,0,1,0,0, 1,0,0, "R2 start cycle");
        step(0,1,0,1,1,0,0, 2,0,0, "R2 active");
        step(0,1,0,1,1,1,0, 1,0,0, "R2 locked end continues to T1");
        step(0,1,0,1,0,0,0, 2,0,0, "R2 active again");
        step(0,1,0,0,0,1,0, 3,0,0, "R1 hold at unlocked cycle end");
        step(0,1,0,0,0,0,0, 3,1,0, "R4 ack after cycle-end grant");
        step(0,0,0,0,1,0,0, 1,1,0, "R7 exit to T1 with request");
        step(0,0,0,0,0,0,0, 2,0,0, "R7 cycle runs");
        step(0,0,0,0,0,1,0, 0,0,0, "R7 back to idle");
        // R3 split narrow transfer
        step(0,0,0,0,1,0,0, 1,0,0, "R3 start");
        step(0,1,0,0,0,0,0, 2,0,0, "R3 active first half");
        step(0,1,0,0,0,1,1, 1,0,0, "R3 first half forces second cycle");
        step(0,1,0,0,0,0,1, 2,0,0, "R3 second half active");
        step(0,1,0,0,0,1,1, 3,0,0, "R3 hold after second half");
        step(0,1,0,0,0,0,0, 3,1,0, "R3 ack");
        step(0,0,0,0,0,0,0, 0,1,0, "R3 exit");
        step(0,0,0,0,0,0,0, 0,0,0, "R3 idle");
        // R5 NMI during hold, R6 ignored inputs
        step(0,1,0,0,0,0,0, 3,0,0, "R5 enter hold");
        step(0,1,1,0,0,0,0, 3,1,0, "R5 first nmi edge");
        step(0,1,0,0,0,0,0, 3,1,0, "R5 nmi low");
        step(0,1,1,1,1,1,1, 3,1,0, "R6 inputs ignored, second edge");
        step(0,1,0,0,1,1,0, 3,1,0, "R6 still in hold");
        step(0,0,0,0,0,0,0, 0,1,1, "R5 event on exit");
        step(0,0,0,0,0,0,0, 0,0,0, "R5 single pulse");
        // R5 edge outside hold gives no event
        step(0,0,1,0,0,0,0, 0,0,0, "R5 nmi edge in idle");
        step(0,1,1,0,0,0,0, 3,0,0, "R5 hold with nmi high");
        step(0,1,1,0,0,0,0, 3,1,0, "R5 no edge in hold");
        step(0,0,0,0,0,0,0, 0,1,0, "R5 no event on exit");
        step(0,0,0,0,0,0,0, 0,0,0, "R5 idle");
        // R8 reset in hold clears captured edge, R9 hold after reset release
        step(0,1,0,0,0,0,0, 3,0,0, "R8 enter hold");
        step(0,1,1,0,0,0,0, 3,1,0, "R8 capture edge");
        step(1,1,0,0,0,0,0, 0,0,0, "R8 reset exits hold");
        step(1,1,0,0,1,0,0, 0,0,0, "R8 held in reset");
        step(0,1,0,0,1,0,0, 3,0,0, "R9 hold before first cycle");
        step(0,1,0,0,1,0,0, 3,1,0, "R9 ack");
        step(0,0,0,0,0,0,0, 0,1,0, "R8 captured edge discarded");
        step(0,0,0,0,0,0,0, 0,0,0, "R8 idle");
        // reset in mid bus cycle
        step(0,0,0,0,1,0,0, 1,0,0, "R8 start cycle");
        step(1,0,0,0,1,0,0, 0,0,0, "R8 reset aborts cycle");
        step(0,0,0,0,0,0,0, 0,0,0, "R8 idle after abort");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout, expected completion");
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule